// File: doc/BRIEF.md
# Chroma 4:1:1 to sequential U/V reformatter

This block takes a 4-bit chroma bus on which a single U sample and a single V sample are spread over a group of four master-clock cycles. Each component uses two lanes, and its bit pairs arrive most significant first. The block gathers the eight bits of each component and emits the finished pair as an 8-bit word stream. The word is U for two clocks and then V for two clocks, so a new word appears every second master clock.

A strobe marks the first cycle of each group and forces the internal phase back to zero. When the strobe is absent, the phase simply counts modulo four.

Two mode inputs set the number format and the precision of every emitted sample:
- The format input flips the sample MSB, which converts between offset-binary and signed coding.
- The precision input clears the sample LSB.

Both modes are sampled on the last cycle of a group, together with the final nibble.

Top module: `chroma_seq_fmt`

## Requirements
- R1: While reset is high, and on the first cycle after it with no strobe, `is_u` is 1 and `chroma_out` is 0. The cycle after reset with no strobe is phase 0.
- R2: Bus bit 3 carries U bits 7,5,3,1 on phases 0..3 and bus bit 2 carries U bits 6,4,2,0, so the U word emitted equals the U bits sent.
- R3: Bus bit 1 carries V bits 7,5,3,1 on phases 0..3 and bus bit 0 carries V bits 6,4,2,0, so the V word emitted equals the V bits sent.
- R4: A pair completed in a group's phase 3 is output throughout the following group: U in phases 0 and 1, V in phases 2 and 3. `is_u` is 1 exactly while U is on the output.
- R5: A cycle with `grp_start` high is phase 0, whatever the previous phase was.
- R6: Without `grp_start` the phase advances 0,1,2,3,0 on every clock.
- R7: With `fmt_twos` = 1, bit 7 of each emitted sample is the inverse of the bit sent.
- R8: With `prec_7b` = 1, bit 0 of each emitted sample is 0.
- R9: Only the values of `fmt_twos` and `prec_7b` in a group's phase 3 cycle affect that group's pair. Their values in phases 0 to 2 have no effect.
- R10: A group cut short by a strobe before phase 3 does not replace the held pair. The previous pair is output again in the next group.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| uv_nib | input | 4 | Nibble-serial chroma bus (3:2 U lanes, 1:0 V lanes) |
| grp_start | input | 1 | High on the first cycle of a 4-cycle group |
| fmt_twos | input | 1 | 1: invert sample MSB (two's complement mode) |
| prec_7b | input | 1 | 1: 7-bit mode, sample LSB forced to 0 |
| chroma_out | output | 8 | Sequential U/V chroma word |
| is_u | output | 1 | 1 while `chroma_out` holds U |

## Verification
The bench sends pairs whose U and V bits differ lane by lane. A design that swapped the two lanes of a component, or reversed the pair order, shows a wrong word at once.

The mode inputs are driven to the opposite value during phases 0 to 2 of every group. A design that samples the modes at the wrong phase therefore formats the sample wrongly.

Some groups run without a strobe, and one group is cut to two cycles by a fresh strobe. A counter that does not free-run, ignores the strobe, or loads a partial pair is caught by the `is_u` pattern or by the held pair changing when it should not.

// File: rtl/chroma_seq_pkg.sv
package chroma_seq_pkg;

    localparam int NIB_W     = 4;
    localparam int SAMP_W    = 8;
    localparam int LANES_PER = NIB_W / 2;
    localparam int GROUP_LEN = SAMP_W / LANES_PER;
    localparam int PH_W      = $clog2(GROUP_LEN);
    localparam int ACC_W     = SAMP_W - LANES_PER;

    typedef enum logic [PH_W-1:0] {
        PH_U_A = 2'd0,
        PH_U_B = 2'd1,
        PH_V_A = 2'd2,
        PH_V_B = 2'd3
    } phase_e;

    typedef struct packed {
        logic [SAMP_W-1:0] u;
        logic [SAMP_W-1:0] v;
    } uv_pair_t;

    function automatic logic [SAMP_W-1:0] apply_modes(
        input logic [SAMP_W-1:0] raw,
        input logic              twos,
        input logic              seven
    );
        logic [SAMP_W-1:0] r;
        r = raw;
        if (twos)  r[SAMP_W-1] = ~raw[SAMP_W-1];
        if (seven) r[0]        = 1'b0;
        return r;
    endfunction

endpackage

// File: rtl/chroma_phase_ctr.sv
module chroma_phase_ctr
    import chroma_seq_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   grp_start,
    output phase_e ph
);
    phase_e ph_q;

    always_comb begin
        if (grp_start) ph = PH_U_A;
        else           ph = phase_e'(ph_q + 1'b1);
    end

    always_ff @(posedge clk) begin
        if (rst) ph_q <= PH_V_B;
        else     ph_q <= ph;
    end
endmodule

// File: rtl/chroma_lane_deser.sv
module chroma_lane_deser
    import chroma_seq_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  logic [NIB_W-1:0] uv_nib,
    input  phase_e           ph,
    input  logic             fmt_twos,
    input  logic             prec_7b,
    output uv_pair_t         held
);
    localparam int NCOMP = NIB_W / LANES_PER;

    logic [SAMP_W-1:0] full [NCOMP];

    for (genvar c = 0; c < NCOMP; c++) begin : g_comp
        localparam int HI = NIB_W - 1 - c * LANES_PER;
        logic [ACC_W-1:0]     acc;
        logic [LANES_PER-1:0] pair_now;

        assign pair_now = uv_nib[HI -: LANES_PER];
        assign full[c]  = {acc, pair_now};

        always_ff @(posedge clk) begin
            if (rst) acc <= '0;
            else     acc <= {acc[ACC_W-LANES_PER-1:0], pair_now};
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            held <= '0;
        end else if (ph == PH_V_B) begin
            held.u <= apply_modes(full[0], fmt_twos, prec_7b);
            held.v <= apply_modes(full[1], fmt_twos, prec_7b);
        end
    end
endmodule

// File: rtl/chroma_out_sel.sv
module chroma_out_sel
    import chroma_seq_pkg::*;
(
    input  uv_pair_t          held,
    input  phase_e            ph,
    output logic [SAMP_W-1:0] chroma_out,
    output logic              is_u
);
    always_comb begin
        unique case (ph)
            PH_U_A, PH_U_B: begin
                chroma_out = held.u;
                is_u       = 1'b1;
            end
            default: begin
                chroma_out = held.v;
                is_u       = 1'b0;
            end
        endcase
    end
endmodule

// File: rtl/chroma_seq_fmt.sv
module chroma_seq_fmt
    import chroma_seq_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic [NIB_W-1:0]  uv_nib,
    input  logic              grp_start,
    input  logic              fmt_twos,
    input  logic              prec_7b,
    output logic [SAMP_W-1:0] chroma_out,
    output logic              is_u
);
    phase_e   ph_cur;
    uv_pair_t pair_held;

    chroma_phase_ctr u_phase (
        .clk       (clk),
        .rst       (rst),
        .grp_start (grp_start),
        .ph        (ph_cur)
    );

    chroma_lane_deser u_deser (
        .clk      (clk),
        .rst      (rst),
        .uv_nib   (uv_nib),
        .ph       (ph_cur),
        .fmt_twos (fmt_twos),
        .prec_7b  (prec_7b),
        .held     (pair_held)
    );

    chroma_out_sel u_sel (
        .held       (pair_held),
        .ph         (ph_cur),
        .chroma_out (chroma_out),
        .is_u       (is_u)
    );
endmodule

// File: rtl/chroma_seq_fmt_chk.sv
module chroma_seq_fmt_chk (
    input logic       clk,
    input logic       rst,
    input logic       grp_start,
    input logic       prec_7b,
    input logic [7:0] chroma_out,
    input logic       is_u,
    input logic [1:0] ph
);
    p_strobe_u_first_r5: assert property (@(posedge clk) disable iff (rst)
        grp_start |-> is_u);

    p_free_run_r6: assert property (@(posedge clk) disable iff (rst)
        (!grp_start && !$past(rst)) |-> (ph == 2'($past(ph) + 2'd1)));

    p_word_held_two_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && (ph == 2'd1 || ph == 2'd3)) |-> $stable(chroma_out));

    p_u_then_v_r4: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && ph == 2'd2) |-> ($past(is_u) && !is_u));

    p_lsb_clear_r8: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && $past(ph) == 2'd3 && $past(prec_7b)) |-> (chroma_out[0] == 1'b0));
endmodule

bind chroma_seq_fmt chroma_seq_fmt_chk u_chk (
    .clk        (clk),
    .rst        (rst),
    .grp_start  (grp_start),
    .prec_7b    (prec_7b),
    .chroma_out (chroma_out),
    .is_u       (is_u),
    .ph         (ph_cur)
);

// File: tb/chroma_seq_fmt_bench.sv
module chroma_seq_fmt_bench;

    typedef struct {
        logic [7:0] u;
        logic [7:0] v;
        string      tag_u;
        string      tag_v;
        string      tag_ph;
    } exp_item_t;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [3:0] uv_nib = '0;
    logic       grp_start = 1'b0;
    logic       fmt_twos = 1'b0;
    logic       prec_7b = 1'b0;
    logic [7:0] chroma_out;
    logic       is_u;

    int checks = 0;
    int errors = 0;

    exp_item_t q[$];
    exp_item_t last_item;
    exp_item_t cur;
    int        bph = 3;

    always #10 clk = ~clk;

    chroma_seq_fmt u_chroma_seq_fmt (
        .clk        (clk),
        .rst        (rst),
        .uv_nib     (uv_nib),
        .grp_start  (grp_start),
        .fmt_twos   (fmt_twos),
        .prec_7b    (prec_7b),
        .chroma_out (chroma_out),
        .is_u       (is_u)
    );

    function automatic logic [7:0] expect_fmt(logic [7:0] s, logic twos, logic seven);
        logic [7:0] r = s;
        if (twos)  r[7] = ~r[7];
        if (seven) r[0] = 1'b0;
        return r;
    endfunction

    task automatic chk(string tag, logic [7:0] act, logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic send_group(logic [7:0] u, logic [7:0] v, logic twos, logic seven,
                              logic strobe, int len, string tu, string tv, string tp);
        exp_item_t it;
        for (int k = 0; k < len; k++) begin
            @(posedge clk); #2;
            grp_start = strobe && (k == 0);
            uv_nib    = {u[7-2*k], u[6-2*k], v[7-2*k], v[6-2*k]};
            fmt_twos  = (k == 3) ? twos  : ~twos;
            prec_7b   = (k == 3) ? seven : ~seven;
            if (k == 3) begin
                it.u = expect_fmt(u, twos, seven);
                it.v = expect_fmt(v, twos, seven);
                it.tag_u = tu; it.tag_v = tv; it.tag_ph = tp;
                q.push_back(it);
                last_item = it;
            end else if (k == len - 1) begin
                it = last_item;
                it.tag_u = "R10"; it.tag_v = "R10"; it.tag_ph = "R5";
                q.push_back(it);
            end
        end
    endtask

    always @(negedge clk) begin
        if (rst) begin
            chk("R1", {7'd0, is_u}, 8'd1);
            chk("R1", chroma_out, 8'h00);
            bph = 3;
            cur.u = '0; cur.v = '0;
            cur.tag_u = "R1"; cur.tag_v = "R1"; cur.tag_ph = "R1";
        end else begin
            bph = grp_start ? 0 : (bph + 1) % 4;
            if (bph == 0 && q.size() > 0) cur = q.pop_front();
            chk(grp_start ? "R5" : cur.tag_ph, {7'd0, is_u}, {7'd0, bph < 2});
            if (bph < 2) chk(cur.tag_u, chroma_out, cur.u);
            else         chk(cur.tag_v, chroma_out, cur.v);
        end
    end

    initial begin
        repeat (20000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        #2 rst = 1'b0;
        // R2 R3 R4: strobed groups, plain binary 8-bit
        send_group(8'hA5, 8'h3C, 0, 0, 1, 4, "R2", "R3", "R4");
        send_group(8'hFF, 8'h00, 0, 0, 1, 4, "R2", "R3", "R4");
        send_group(8'h01, 8'h80, 0, 0, 1, 4, "R2", "R3", "R4");
        // R6: free-running phase, no strobe
        send_group(8'h96, 8'h69, 0, 0, 0, 4, "R2", "R3", "R6");
        send_group(8'h7E, 8'hE7, 0, 0, 0, 4, "R2", "R3", "R6");
        // R7 R8: modes (R9: opposite mode driven in phases 0..2)
        send_group(8'h80, 8'h7F, 1, 0, 1, 4, "R7", "R7", "R4");
        send_group(8'h55, 8'hAB, 0, 1, 1, 4, "R8", "R8", "R4");
        send_group(8'hC3, 8'h3D, 1, 1, 1, 4, "R7", "R8", "R4");
        send_group(8'h12, 8'h34, 0, 0, 1, 4, "R9", "R9", "R4");
        // R10 and R5: short group then fresh strobe
        send_group(8'hEE, 8'h11, 0, 0, 1, 2, "R10", "R10", "R5");
        send_group(8'h5A, 8'hA5, 0, 0, 1, 4, "R2", "R3", "R5");
        send_group(8'h00, 8'h00, 0, 0, 1, 4, "R2", "R3", "R4");
        repeat (6) @(posedge clk);
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule